// File: doc/BRIEF.md
# Chainable Periodic Interrupt Timer

A bank of four down-counting timer channels behind a small register interface. All channels advance on one shared tick-enable input. An enabled channel decrements on each tick. When it is at zero on a tick it raises its expiry flag and reloads from its load register. The time between expiries is therefore the load value plus one ticks.

Any channel except the first can be linked to the channel below it. A linked channel decrements only on the ticks where its lower neighbour expires. Linking channel 1 onto channel 0 gives a 64-bit lifetime count, with channel 1 as the upper half. Software reads this count through a high and low register pair. Reading the high word captures the low word in the same cycle, so the two halves always belong together.

A global halt bit freezes every channel. A single interrupt line reports any enabled expiry.

Top module: `chained_period_timer`

## Requirements
- R1: An enabled channel that is not halted decrements by one on each `tick` cycle. A tick that finds the count at 0 sets the channel flag and reloads the count from the load register.
- R2: Writing the load register (channel offset 0x0) leaves the current count unchanged. The new value is used at the next reload.
- R3: Writing the channel control register (offset 0x8) with the run bit (bit 0) at 1, while run was 0, sets the count to the load value. A stopped channel holds its count.
- R4: A channel whose link bit (control bit 2) is set decrements only in cycles where the channel below it expires. It ignores `tick` otherwise.
- R5: Reading the lifetime-high register (0x04) returns channel 1's count and captures channel 0's count in the same cycle. The lifetime-low register (0x08) returns that captured value.
- R6: Writing 1 to bit 0 of a channel's flag register (offset 0xC) clears the flag. If an expiry happens in the same cycle, the flag stays set.
- R7: `irq` is high while any channel has both its flag and its interrupt-enable bit (control bit 1) set.
- R8: While bit 0 of the module control register (0x00) is set, no channel's count changes.
- R9: Counts change only in `tick` cycles. Channels started at different times each count their own ticks from their own start.
- R10: Channel 0 has no lower neighbour. Its link bit reads back as 0 and does not stop it from counting on `tick`.
- R11: With a load value of 0, an enabled channel expires on every tick.
- R12: After reset, every register reads 0 and `irq` is low.

Channel n (0 to 3) occupies byte addresses 0x10*(n+1) through 0x10*(n+1)+0xC. Its count register is at offset 0x4 and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count enable for all channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; used for the lifetime capture |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid in the same cycle |
| irq | output | 1 | Combined interrupt |

## Verification
Two situations are hardest to reach from the ports. The first is a flag clear that lands in the same cycle as a fresh expiry. The bench reaches it by loading 0 into a channel so that it expires on every tick, then raising the clear write and `tick` together in one cycle. The second is the lifetime capture. Here the bench reads the high word, lets channel 0 move on by a tick, and then reads the low word. The low word must hold the earlier value, and a read of the live count must return the newer one. A 64-bit rollover is not practical to wait for, so small load values keep the linked pair's carries within a few ticks.

// File: rtl/chained_period_timer.sv
`timescale 1ns/1ps
module chained_period_timer #(
  parameter int NCH = 4,
  parameter int W   = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq
);
  localparam int RW = AW - 4;
  localparam logic [AW-1:0] A_MCTL = AW'(0);
  localparam logic [AW-1:0] A_LHI  = AW'(4);
  localparam logic [AW-1:0] A_LLO  = AW'(8);

  logic [W-1:0]   load_q [NCH];
  logic [W-1:0]   cnt_q  [NCH];
  logic [NCH-1:0] run_q, ie_q, link_q, flag_q;
  logic           halt_q;
  logic [W-1:0]   snap_q;

  logic [NCH-1:0] adv, expire, hit, wr_load, wr_ctl, wr_clr, restart;

  always_comb begin
    logic prev;
    prev = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      adv[i]    = run_q[i] && !halt_q && (link_q[i] ? prev : tick);
      expire[i] = adv[i] && (cnt_q[i] == '0);
      prev      = expire[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i]     = addr[AW-1:4] == RW'(i + 1);
      wr_load[i] = wr_en && hit[i] && addr[3:2] == 2'd0;
      wr_ctl[i]  = wr_en && hit[i] && addr[3:2] == 2'd2;
      wr_clr[i]  = wr_en && hit[i] && addr[3:2] == 2'd3 && wdata[0];
      restart[i] = wr_ctl[i] && wdata[0] && !run_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      snap_q <= '0;
      run_q  <= '0;
      ie_q   <= '0;
      link_q <= '0;
      flag_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        load_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      if (wr_en && addr == A_MCTL) halt_q <= wdata[0];
      if (rd_en && addr == A_LHI)  snap_q <= cnt_q[0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_load[i]) load_q[i] <= wdata;
        if (wr_ctl[i]) begin
          run_q[i]  <= wdata[0];
          ie_q[i]   <= wdata[1];
          link_q[i] <= (i != 0) && wdata[2];
        end
        if (restart[i])   cnt_q[i] <= load_q[i];
        else if (adv[i])  cnt_q[i] <= expire[i] ? load_q[i] : cnt_q[i] - W'(1);
        if (expire[i])      flag_q[i] <= 1'b1;
        else if (wr_clr[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_MCTL) rdata[0] = halt_q;
    if (addr == A_LHI)  rdata = cnt_q[1];
    if (addr == A_LLO)  rdata = snap_q;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) begin
        case (addr[3:2])
          2'd0: rdata = load_q[i];
          2'd1: rdata = cnt_q[i];
          2'd2: rdata = {{(W-3){1'b0}}, link_q[i], ie_q[i], run_q[i]};
          default: rdata = {{(W-1){1'b0}}, flag_q[i]};
        endcase
      end
    end
  end

  assign irq = |(flag_q & ie_q);

  assert_ch0_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q[0] && !halt_q && tick && !wr_en && cnt_q[0] != '0) |=> cnt_q[0] == $past(cnt_q[0] - W'(1)));

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && expire == '0 && !irq) |=> !irq);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_flag_on_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> flag_q[g]);
    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_en) |=> $stable(cnt_q[g]));
    assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(cnt_q[g]));
  end
endmodule

// File: tb/chained_period_timer_bench.sv
`timescale 1ns/1ps
module chained_period_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chained_period_timer u_chained_period_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  localparam int NV = 8;
  localparam int unsigned TL [NV] = '{5, 5, 5, 0, 0, 2, 10, 10};
  localparam int unsigned TN [NV] = '{3, 6, 8, 1, 0, 7, 10, 11};
  localparam int unsigned TC [NV] = '{2, 5, 3, 0, 0, 1, 0, 10};
  localparam int unsigned TF [NV] = '{0, 1, 1, 1, 0, 1, 0, 1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h14, v); chk("R12 reset count", v, 0);
    rd(8'h18, v); chk("R12 reset ctrl", v, 0);
    rd(8'h00, v); chk("R12 reset module ctrl", v, 0);
    chk("R12 reset irq", irq, 0);
    ticks(3);
    rd(8'h14, v); chk("R3 stopped channel holds", v, 0);

    for (int e = 0; e < NV; e++) begin
      wr(8'h18, 0); wr(8'h1C, 1); wr(8'h10, TL[e]); wr(8'h18, 1);
      ticks(TN[e]);
      rd(8'h14, v); chk($sformatf("R1 R11 vector %0d count", e), v, TC[e]);
      rd(8'h1C, v); chk($sformatf("R1 R11 vector %0d flag", e), v, TF[e]);
      chk($sformatf("R7 vector %0d irq masked", e), irq, 0);
    end

    wr(8'h18, 0); wr(8'h1C, 1); wr(8'h10, 4); wr(8'h18, 1);
    ticks(2);
    wr(8'h10, 9);
    rd(8'h14, v); chk("R2 load write keeps count", v, 2);
    ticks(3);
    rd(8'h14, v); chk("R2 new load used at reload", v, 9);

    ticks(4);
    wr(8'h18, 0);
    ticks(2);
    rd(8'h14, v); chk("R3 stopped count held", v, 5);
    wr(8'h10, 7); wr(8'h18, 1);
    rd(8'h14, v); chk("R3 restart reloads", v, 7);

    wr(8'h18, 0); wr(8'h1C, 1); wr(8'h10, 0); wr(8'h18, 3);
    ticks(1);
    rd(8'h1C, v); chk("R11 load zero expires", v, 1);
    chk("R7 irq on enabled flag", irq, 1);
    wr(8'h1C, 1);
    rd(8'h1C, v); chk("R6 write-one clears", v, 0);
    chk("R7 irq drops after clear", irq, 0);
    wr_en = 1'b1; addr = 8'h1C; wdata = 1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(8'h1C, v); chk("R6 expiry beats clear", v, 1);
    wr(8'h18, 0);
    chk("R7 irq masked with flag set", irq, 0);
    wr(8'h18, 2);
    chk("R7 irq from enable alone", irq, 1);
    wr(8'h1C, 1);
    wr(8'h18, 0);

    wr(8'h10, 5); wr(8'h18, 1);
    ticks(1);
    wr(8'h00, 1);
    ticks(3);
    rd(8'h14, v); chk("R8 halt freezes count", v, 4);
    rd(8'h00, v); chk("R8 halt bit reads back", v, 1);
    wr(8'h00, 0);
    ticks(1);
    rd(8'h14, v); chk("R8 resumes after halt", v, 3);

    wr(8'h18, 0); wr(8'h28, 0); wr(8'h1C, 1); wr(8'h2C, 1);
    wr(8'h20, 9); wr(8'h10, 2); wr(8'h28, 5); wr(8'h18, 1);
    ticks(2);
    rd(8'h24, v); chk("R4 linked channel ignores tick", v, 9);
    ticks(1);
    rd(8'h24, v); chk("R4 linked channel steps on expiry", v, 8);
    rd(8'h14, v); chk("R4 lower channel reloaded", v, 2);
    ticks(3);
    rd(8'h24, v); chk("R4 second carry", v, 7);

    rd(8'h04, v); chk("R5 lifetime high", v, 7);
    ticks(1);
    rd(8'h08, v); chk("R5 lifetime low is captured", v, 2);
    rd(8'h14, v); chk("R5 live low moved on", v, 1);

    wr(8'h18, 5);
    rd(8'h18, v); chk("R10 channel 0 link reads 0", v, 1);
    ticks(1);
    rd(8'h14, v); chk("R10 channel 0 still counts ticks", v, 0);

    wr(8'h30, 3); wr(8'h38, 1);
    ticks(1);
    wr(8'h40, 3); wr(8'h48, 1);
    ticks(1);
    rd(8'h34, v); chk("R9 early channel", v, 1);
    rd(8'h44, v); chk("R9 late channel", v, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule